// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block decides when a debug session reaches its trigger point. Software arms it, and it then leaves its idle state for the first of three sequencing states. Each sequencing state has its own 4-bit control field. The field says how comparator matches move the sequencer between the sequencing states and into a Final State.

Alongside the matches, three stronger trigger sources are watched:

- a software force-trigger request;
- an external tag input;
- a coprocessor breakpoint input.

When several triggers land in one cycle, a fixed priority keeps one and drops the rest. The trace alignment mode then decides three things: whether a trigger enters the Final State or ends the session outright, when a forced breakpoint request is raised, and when the arm flag falls. Trace completion is reported by a neighbouring block through an input.

The state is visible as a 3-bit code: 0 idle, 1 to 3 the sequencing states, 4 the Final State. The breakpoint request and the session-complete flag are one-cycle registered pulses. They appear in the same cycle as the state change that caused them.

Top module: `dbg_seq_core`

## Requirements
- R1: After reset the block is disarmed, the state code is 0 and both pulse outputs are low.
- R2: An arm request while disarmed sets the arm flag and moves to state 1 at the next edge. An arm request while armed has no effect. A disarm request at any time clears the arm flag and returns to state 0 with no pulse, and it wins over an arm request in the same cycle. Triggers seen while disarmed have no effect.
- R3: Triggers are resolved in a fixed order, highest first: force-trigger, external tag, coprocessor breakpoint, then comparator matches. A lower trigger in the same cycle is discarded.
- R4: A force-trigger in states 1 to 3 behaves according to the alignment code (align_i: 0 none, 1 begin, 2 mid, 3 end).
  - With begin or mid alignment it moves to state 4.
  - With end or no alignment it clears the arm flag, returns to state 0 and pulses session-complete. It also pulses the breakpoint request when breakpoints are enabled.
- R5: An external tag or coprocessor breakpoint in states 1 to 4 ends the session. It pulses the breakpoint request whatever the breakpoint enable, clears the arm flag, returns to state 0 and pulses session-complete.
- R6: The control field of the current state (state k uses step_ctl_i[4k-1:4k-4]) decodes by its bits [3:2].
  - Code 01: a match on channel field[1:0] goes to state 4, and any other match steps in the ring 1 to 2 to 3 to 1.
  - Code 10: channels 0, 1 and 2 go to states 1, 2 and 3, and channel 3 goes to state 4.
- R7: Among simultaneous matches the one leading to state 4 wins. Otherwise the lowest channel number wins.
- R8: With range_mode_i high, a match on channel 2 is discarded whenever channel 0 matches in the same cycle.
- R9: In state 4, force-trigger and matches are ignored. trace_done_i clears the arm flag, returns to state 0 and pulses session-complete, plus the breakpoint request when breakpoints are enabled.
- R10: A match leading to state 4 with end or no alignment ends the session at once, exactly as a force-trigger does under R4.
- R11: An arm request in the same cycle as a hardware end of session leaves the block disarmed in state 0.
- R12: Field codes 00 and 11 in bits [3:2] ignore all matches and hold the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_set_i | input | 1 | Software arm request |
| arm_clr_i | input | 1 | Software disarm request |
| force_trig_i | input | 1 | Software force-trigger |
| ext_tag_i | input | 1 | External tag hit |
| cop_bkpt_i | input | 1 | Coprocessor breakpoint |
| match_i | input | 4 | Comparator match per channel |
| range_mode_i | input | 1 | Comparators paired as ranges |
| align_i | input | 2 | Trace alignment code |
| bkpt_en_i | input | 1 | Breakpoints enabled |
| step_ctl_i | input | 12 | Control fields for states 1, 2 and 3 |
| trace_done_i | input | 1 | Trace capture finished |
| arm_o | output | 1 | Arm flag |
| state_o | output | 3 | Current state code |
| bkpt_req_o | output | 1 | Forced breakpoint request pulse |
| sess_done_o | output | 1 | Session complete pulse |

## Verification
The hardest case to reach is a cycle where several trigger classes collide in a deep state. Examples are a force-trigger together with a tag and matches in state 3, or a tag together with a software arm request. Reaching such a cycle first requires a chain of correctly ordered matches under suitable control fields. Directed sessions build those chains step by step and then fire the collisions. Seeded random cycles follow, with low trigger rates so that sessions often travel deep before they end.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  localparam int NUM_CH  = 4;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int FIELD_W = 4;
  localparam int NUM_SEQ = 3;
  localparam int CTL_W   = FIELD_W * NUM_SEQ;
  localparam int ST_W    = 3;
  localparam int NUM_REQ = 4;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FINAL = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    AL_NONE  = 2'd0,
    AL_BEGIN = 2'd1,
    AL_MID   = 2'd2,
    AL_END   = 2'd3
  } align_t;

  // index of each request in the arbiter vector, lower index wins
  localparam int RQ_FORCE = 0;
  localparam int RQ_TAG   = 1;
  localparam int RQ_COP   = 2;
  localparam int RQ_MATCH = 3;

endpackage

// File: rtl/dbg_match_sel.sv
module dbg_match_sel
  import dbg_seq_pkg::*;
(
  input  logic [NUM_CH-1:0]  match_i,
  input  logic               range_mode_i,
  input  logic [FIELD_W-1:0] field_i,
  input  seq_state_t         cur_i,
  output logic               hit_o,
  output seq_state_t         tgt_o
);

  logic [NUM_CH-1:0] eff;
  logic [CH_W-1:0]   fin_ch;
  seq_state_t        ring_nxt;

  // range pairing drops channel 2 when channel 0 fires with it
  always_comb begin
    eff = match_i;
    if (range_mode_i && match_i[0]) eff[2] = 1'b0;
  end

  assign fin_ch = field_i[CH_W-1:0];

  always_comb begin
    case (cur_i)
      ST_ONE:   ring_nxt = ST_TWO;
      ST_TWO:   ring_nxt = ST_THREE;
      default:  ring_nxt = ST_ONE;
    endcase
  end

  always_comb begin
    hit_o = 1'b0;
    tgt_o = cur_i;
    case (field_i[FIELD_W-1:FIELD_W-2])
      2'b01: begin
        if (eff[fin_ch]) begin
          hit_o = 1'b1;
          tgt_o = ST_FINAL;
        end else if (|eff) begin
          hit_o = 1'b1;
          tgt_o = ring_nxt;
        end
      end
      2'b10: begin
        if (eff[NUM_CH-1]) begin
          hit_o = 1'b1;
          tgt_o = ST_FINAL;
        end else begin
          // scan downwards so the lowest channel is assigned last
          for (int c = NUM_CH - 2; c >= 0; c--) begin
            if (eff[c]) begin
              hit_o = 1'b1;
              case (c)
                0:       tgt_o = ST_ONE;
                1:       tgt_o = ST_TWO;
                default: tgt_o = ST_THREE;
              endcase
            end
          end
        end
      end
      default: begin
        hit_o = 1'b0;
        tgt_o = cur_i;
      end
    endcase
  end

endmodule

// File: rtl/dbg_trig_arb.sv
module dbg_trig_arb
  import dbg_seq_pkg::*;
(
  input  logic               in_seq_i,
  input  logic               in_final_i,
  input  logic               force_i,
  input  logic               tag_i,
  input  logic               cop_i,
  input  logic               hit_i,
  output logic [NUM_REQ-1:0] grant_o
);

  logic [NUM_REQ-1:0] req;
  logic               live;

  assign live = in_seq_i | in_final_i;

  always_comb begin
    req           = '0;
    req[RQ_FORCE] = force_i & in_seq_i;
    req[RQ_TAG]   = tag_i   & live;
    req[RQ_COP]   = cop_i   & live;
    req[RQ_MATCH] = hit_i   & in_seq_i;
  end

  always_comb begin
    grant_o = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_set_i,
  input  logic               arm_clr_i,
  input  logic [NUM_REQ-1:0] grant_i,
  input  seq_state_t         tgt_i,
  input  align_t             align_i,
  input  logic               bkpt_en_i,
  input  logic               trace_done_i,
  input  logic               tag_i,
  input  logic               cop_i,
  output logic               arm_o,
  output seq_state_t         state_o,
  output logic               bkpt_o,
  output logic               done_o
);

  logic       arm_q, arm_d;
  seq_state_t st_q, st_d;
  logic       bk_q, bk_d;
  logic       sd_q, sd_d;
  logic       end_sess;
  logic       end_bk;
  logic       keep_trace;
  logic       in_seq;

  assign keep_trace = (align_i == AL_BEGIN) || (align_i == AL_MID);
  assign in_seq     = (st_q == ST_ONE) || (st_q == ST_TWO) || (st_q == ST_THREE);

  // next-state process
  always_comb begin
    arm_d    = arm_q;
    st_d     = st_q;
    end_sess = 1'b0;
    end_bk   = 1'b0;
    if (arm_clr_i) begin
      arm_d = 1'b0;
      st_d  = ST_IDLE;
    end else if (!arm_q || st_q == ST_IDLE) begin
      if (arm_set_i) begin
        arm_d = 1'b1;
        st_d  = ST_ONE;
      end
    end else if (st_q == ST_FINAL) begin
      if (grant_i[RQ_TAG] || grant_i[RQ_COP]) begin
        end_sess = 1'b1;
        end_bk   = 1'b1;
      end else if (trace_done_i) begin
        end_sess = 1'b1;
        end_bk   = bkpt_en_i;
      end
    end else begin
      if (grant_i[RQ_FORCE]) begin
        if (keep_trace) st_d = ST_FINAL;
        else begin
          end_sess = 1'b1;
          end_bk   = bkpt_en_i;
        end
      end else if (grant_i[RQ_TAG] || grant_i[RQ_COP]) begin
        end_sess = 1'b1;
        end_bk   = 1'b1;
      end else if (grant_i[RQ_MATCH]) begin
        if (tgt_i == ST_FINAL && !keep_trace) begin
          end_sess = 1'b1;
          end_bk   = bkpt_en_i;
        end else begin
          st_d = tgt_i;
        end
      end
    end
    if (end_sess) begin
      // hardware end of session beats a concurrent arm request
      arm_d = 1'b0;
      st_d  = ST_IDLE;
    end
    bk_d = end_bk;
    sd_d = end_sess;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      st_q  <= ST_IDLE;
      bk_q  <= 1'b0;
      sd_q  <= 1'b0;
    end else begin
      arm_q <= arm_d;
      st_q  <= st_d;
      bk_q  <= bk_d;
      sd_q  <= sd_d;
    end
  end

  assign arm_o   = arm_q;
  assign state_o = st_q;
  assign bkpt_o  = bk_q;
  assign done_o  = sd_q;

  // assertions

  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_i))
    else $error("p_one_grant_r3");

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_clr_i |=> (!arm_q && st_q == ST_IDLE && !sd_q))
    else $error("p_clear_wins_r2");

  p_arm_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_q && arm_set_i && !arm_clr_i) |=> (arm_q && st_q == ST_ONE))
    else $error("p_arm_enter_r2");

  p_break_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && !arm_clr_i && (in_seq || st_q == ST_FINAL) && (tag_i || cop_i)
     && !(in_seq && grant_i[RQ_FORCE]))
    |=> (!arm_q && bk_q && sd_q))
    else $error("p_break_ends_r5");

  p_final_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FINAL && !arm_clr_i && !tag_i && !cop_i && !trace_done_i)
    |=> (st_q == ST_FINAL && arm_q))
    else $error("p_final_waits_r9");

  p_idle_disarmed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sd_q |-> (!arm_q && st_q == ST_IDLE))
    else $error("p_idle_disarmed_r11");

endmodule

// File: rtl/dbg_seq_core.sv
module dbg_seq_core
  import dbg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_set_i,
  input  logic              arm_clr_i,
  input  logic              force_trig_i,
  input  logic              ext_tag_i,
  input  logic              cop_bkpt_i,
  input  logic [NUM_CH-1:0] match_i,
  input  logic              range_mode_i,
  input  logic [1:0]        align_i,
  input  logic              bkpt_en_i,
  input  logic [CTL_W-1:0]  step_ctl_i,
  input  logic              trace_done_i,
  output logic              arm_o,
  output logic [ST_W-1:0]   state_o,
  output logic              bkpt_req_o,
  output logic              sess_done_o
);

  seq_state_t         cur;
  logic [FIELD_W-1:0] field;
  logic               hit;
  seq_state_t         tgt;
  logic [NUM_REQ-1:0] grant;
  logic               in_seq;
  logic               in_final;
  logic               arm_q;

  // pick the control field of the current sequencing state
  always_comb begin
    field = '0;
    for (int k = 1; k <= NUM_SEQ; k++) begin
      if (cur == seq_state_t'(k)) field = step_ctl_i[FIELD_W*(k-1) +: FIELD_W];
    end
  end

  assign in_seq   = arm_q && (cur == ST_ONE || cur == ST_TWO || cur == ST_THREE);
  assign in_final = arm_q && (cur == ST_FINAL);

  dbg_match_sel u_sel (
    .match_i      (match_i),
    .range_mode_i (range_mode_i),
    .field_i      (field),
    .cur_i        (cur),
    .hit_o        (hit),
    .tgt_o        (tgt)
  );

  dbg_trig_arb u_arb (
    .in_seq_i   (in_seq),
    .in_final_i (in_final),
    .force_i    (force_trig_i),
    .tag_i      (ext_tag_i),
    .cop_i      (cop_bkpt_i),
    .hit_i      (hit),
    .grant_o    (grant)
  );

  dbg_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_set_i    (arm_set_i),
    .arm_clr_i    (arm_clr_i),
    .grant_i      (grant),
    .tgt_i        (tgt),
    .align_i      (align_t'(align_i)),
    .bkpt_en_i    (bkpt_en_i),
    .trace_done_i (trace_done_i),
    .tag_i        (ext_tag_i),
    .cop_i        (cop_bkpt_i),
    .arm_o        (arm_q),
    .state_o      (cur),
    .bkpt_o       (bkpt_req_o),
    .done_o       (sess_done_o)
  );

  assign arm_o   = arm_q;
  assign state_o = cur;

  p_range_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_seq && range_mode_i && match_i[0] && field[3:2] == 2'b01
     && field[1:0] == 2'd2 && !force_trig_i && !ext_tag_i && !cop_bkpt_i && !arm_clr_i)
    |=> (state_o != ST_FINAL[ST_W-1:0]))
    else $error("p_range_drop_r8");

endmodule

// File: tb/sim_dbg_seq_core.sv
module sim_dbg_seq_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        aset, aclr, frc, tag, cop, rng, ben, tdone;
  logic [3:0]  mt;
  logic [1:0]  al;
  logic [11:0] ctl;
  logic        arm_o, bk_o, sd_o;
  logic [2:0]  st_o;

  int checks = 0;
  int errors = 0;
  bit fin = 0;

  logic       m_arm, m_bk, m_sd;
  logic [2:0] m_st;

  always #5 clk = ~clk;

  dbg_seq_core u0 (
    .clk(clk), .rst_n(rst_n), .arm_set_i(aset), .arm_clr_i(aclr),
    .force_trig_i(frc), .ext_tag_i(tag), .cop_bkpt_i(cop), .match_i(mt),
    .range_mode_i(rng), .align_i(al), .bkpt_en_i(ben), .step_ctl_i(ctl),
    .trace_done_i(tdone), .arm_o(arm_o), .state_o(st_o),
    .bkpt_req_o(bk_o), .sess_done_o(sd_o)
  );

  // expected destination of the comparator matches, 0 = no move
  function automatic int exp_target(input logic [2:0] s);
    logic [3:0] f, m;
    f = ctl[4*(s-1) +: 4];
    m = mt;
    if (rng && m[0]) m[2] = 1'b0;
    case (f[3:2])
      2'b01: begin
        if (m[f[1:0]]) return 4;
        if (m != 0) return (s % 3) + 1;
        return 0;
      end
      2'b10: begin
        if (m[3]) return 4;
        if (m[0]) return 1;
        if (m[1]) return 2;
        if (m[2]) return 3;
        return 0;
      end
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    logic na, nb, nd;
    logic [2:0] ns;
    bit trace_kept;
    int t;
    trace_kept = (al == 2'd1) || (al == 2'd2);
    na = m_arm; ns = m_st; nb = 0; nd = 0;
    if (aclr) begin
      na = 0; ns = 0;
    end else if (!m_arm) begin
      if (aset) begin na = 1; ns = 1; end
    end else if (m_st == 3'd4) begin
      if (tag || cop) begin nd = 1; nb = 1; end
      else if (tdone) begin nd = 1; nb = ben; end
    end else begin
      if (frc) begin
        if (trace_kept) ns = 4;
        else begin nd = 1; nb = ben; end
      end else if (tag || cop) begin
        nd = 1; nb = 1;
      end else begin
        t = exp_target(m_st);
        if (t == 4 && !trace_kept) begin nd = 1; nb = ben; end
        else if (t != 0) ns = 3'(t);
      end
    end
    if (nd) begin na = 0; ns = 0; end
    m_arm = na; m_st = ns; m_bk = nb; m_sd = nd;
  endtask

  task automatic check(input string tagname);
    checks++;
    if (arm_o !== m_arm || st_o !== m_st || bk_o !== m_bk || sd_o !== m_sd) begin
      errors++;
      $display("FAIL %s: arm=%0b st=%0d bk=%0b sd=%0b expected arm=%0b st=%0d bk=%0b sd=%0b",
               tagname, arm_o, st_o, bk_o, sd_o, m_arm, m_st, m_bk, m_sd);
    end
  endtask

  task automatic quiet();
    aset = 0; aclr = 0; frc = 0; tag = 0; cop = 0; mt = 4'h0; tdone = 0;
  endtask

  task automatic cyc(input string tagname);
    model_step();
    @(negedge clk);
    check(tagname);
    quiet();
  endtask

  task automatic arm_up(input string tagname);
    aset = 1;
    cyc(tagname);
  endtask

  initial begin
    #2000000;
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL watchdog: arm=%0b st=%0d expected run to end", arm_o, st_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    quiet();
    rng = 0; ben = 0; al = 2'd0; ctl = 12'h000;
    rst_n = 0;
    m_arm = 0; m_st = 0; m_bk = 0; m_sd = 0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after release");

    // triggers while disarmed do nothing
    frc = 1; tag = 1; mt = 4'hF;
    cyc("R2 triggers ignored when idle");

    // session A: begin alignment, walk through the states
    al = 2'd1; ben = 1;
    ctl = {4'b0000, 4'b0111, 4'b1000};
    arm_up("R2 arm enters state 1");
    aset = 1;
    cyc("R2 arm while armed ignored");
    mt = 4'b0110;
    cyc("R7 lowest channel wins");
    mt = 4'b0101;
    cyc("R6 ring step from state 2");
    mt = 4'b1111;
    cyc("R12 code 00 holds");
    frc = 1; tag = 1; mt = 4'hF;
    cyc("R3 force beats tag and matches");
    cyc("R4 begin alignment reaches final");
    frc = 1; mt = 4'hF;
    cyc("R9 force and matches ignored in final");
    tdone = 1;
    cyc("R9 trace done ends session");

    // session B: end alignment, range pairing
    al = 2'd3; ben = 1; rng = 1;
    ctl = {4'b0000, 4'b1100, 4'b0110};
    arm_up("R2 arm session B");
    mt = 4'b0101;
    cyc("R8 range drops channel 2");
    mt = 4'b0001;
    cyc("R12 code 11 holds");
    tag = 1; mt = 4'b1111; aset = 1;
    cyc("R11 tag disarm beats arm request");
    cyc("R5 stays idle after tag");

    // session C: match to final with end alignment
    rng = 0; ben = 0;
    arm_up("R2 arm session C");
    mt = 4'b0101;
    cyc("R10 final match ends at once");

    // session D: no alignment, force
    al = 2'd0; ben = 1;
    arm_up("R2 arm session D");
    frc = 1;
    cyc("R4 force ends session without trace");

    // session E: coprocessor breakpoint with breakpoints disabled
    ben = 0;
    arm_up("R2 arm session E");
    cop = 1; mt = 4'b0001;
    cyc("R5 cop breakpoint ignores enable");

    // session F: software clear beats everything
    arm_up("R2 arm session F");
    aclr = 1; frc = 1; aset = 1;
    cyc("R2 clear beats force and arm");

    // mid alignment force, then tag in final
    al = 2'd2; ben = 0;
    arm_up("R2 arm session G");
    frc = 1;
    cyc("R4 mid alignment reaches final");
    tag = 1;
    cyc("R5 tag ends final state");

    // final by trace done without breakpoints
    al = 2'd1;
    ctl = {4'b1000, 4'b1000, 4'b1000};
    arm_up("R2 arm session H");
    mt = 4'b1001;
    cyc("R7 final match beats lower channel");
    tdone = 1;
    cyc("R9 trace done without breakpoint");

    // seeded random traffic
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      aset  = ($urandom % 4) == 0;
      aclr  = ($urandom % 64) == 0;
      frc   = ($urandom % 16) == 0;
      tag   = ($urandom % 40) == 0;
      cop   = ($urandom % 40) == 0;
      tdone = ($urandom % 8) == 0;
      for (int c = 0; c < 4; c++) mt[c] = ($urandom % 5) == 0;
      if (($urandom % 32) == 0) begin
        al  = 2'($urandom);
        ben = 1'($urandom);
        rng = 1'($urandom);
        ctl = 12'($urandom);
      end
      model_step();
      @(negedge clk);
      check("RND mixed traffic");
    end

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule